// File: doc/BRIEF.md
# Banked Expansion ROM Decoder

This block is the address and strobe decoder for a peripheral card on an 8-bit bus. The card carries one 8K×8 memory device, treated as four 2K banks. The block reaches that device through two host regions. The first is the 256-byte per-slot region, which is active while the active-low I/O-select input is low. The second is the 2K shared window at C800–CFFF, which is active while the active-low I/O-strobe input is low. The block drives only the two upper memory address lines (A11–A12), an active-low chip select, and active-low output and write enables. Address bits A0–A10 go from the host bus to the memory unchanged.

Bank 3 is reserved for the slot region. Every I/O-select cycle puts bank 3 on the upper lines. A8–A10 pass through as well, so the slot region uses eight 256-byte pages of bank 3, and each slot position can hold its own code. The window shows one of banks 0, 1 or 2. Software picks the bank by touching a key address near the top of the window: CFFC selects bank 0, CFFD selects bank 1, and CFFE selects bank 2. The bank number comes from the low two address bits, so the data bus plays no part. The stored bank changes on the clock edge that ends the key access. From the next cycle on, window accesses use the new bank.

Top module: `exp_rom_bank_decoder`

## Requirements
- R1: While reset (active low) is asserted, and on the first cycle after it is released, the stored bank is 0. A window access with I/O-select high then drives mem_hi = 0.
- R2: A cycle with I/O-strobe low, device-select high and an address of CFFC, CFFD or CFFE loads the stored bank with 0, 1 or 2 (the address bits [1:0]) at the closing clock edge. mem_hi shows the new value from the following cycle.
- R3: A strobe access to CFFF, or to any of CFF0–CFFB, leaves the stored bank unchanged.
- R4: While I/O-select is low, mem_hi = 3, whatever bank is stored. An I/O-select cycle never changes the stored bank, even at a key address.
- R5: mem_lo always equals host address bits [10:0], in the same cycle.
- R6: cs_n is low exactly when I/O-select or I/O-strobe is low and device-select is high.
- R7: we_n equals rw (rw = 1 is a read), and oe_n equals the inverse of rw. Both follow rw in the same cycle.
- R8: While device-select is low, cs_n stays high and the stored bank does not change, even with I/O-strobe low at a key address.
- R9: While I/O-select is high, mem_hi shows the stored bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the bank register samples on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the stored bank to 0 |
| addr | input | 16 | Host address bus |
| rw | input | 1 | Host read/write; 1 = read, 0 = write |
| io_sel_n | input | 1 | Active-low per-slot region select |
| io_strb_n | input | 1 | Active-low shared window strobe |
| dev_sel_n | input | 1 | Active-low device register select |
| mem_hi | output | 2 | Memory address lines A11–A12 (bank number) |
| mem_lo | output | 11 | Memory address lines A0–A10, passed through from the host |
| cs_n | output | 1 | Active-low memory chip select |
| oe_n | output | 1 | Active-low memory output enable |
| we_n | output | 1 | Active-low memory write enable |

## Verification
The bank register is the only state in the block, and its only route to the ports is mem_hi during cycles with I/O-select high. A wrong stored bank therefore shows up on the first window or idle cycle after the faulty edge. Slot cycles hide it, because they force bank 3. The stimulus reads the window directly after every key access, after every non-key access to CFFx, and after every slot or device-select cycle made at a key address. This way a missed load, a stray load, or the wrong bank number each shows up within one cycle.

// File: rtl/rom_dec_pkg.sv
package rom_dec_pkg;

   // Decoded bus cycle qualifiers, active high
   typedef struct packed {
      logic rd;
      logic io_sel;
      logic io_strb;
      logic dev_sel;
   } bus_ctl_t;

   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_LOW_W  = 11;
   localparam int unsigned DEF_BANK_W = 2;

endpackage

// File: rtl/rom_ctl_decode.sv
module rom_ctl_decode
   import rom_dec_pkg::*;
#(
   parameter bit GATE_RW_WITH_CS = 1'b0
) (
   input  logic     rw,
   input  logic     io_sel_n,
   input  logic     io_strb_n,
   input  logic     dev_sel_n,
   output bus_ctl_t ctl,
   output logic     cs_n,
   output logic     oe_n,
   output logic     we_n
);

   logic mem_act;

   always_comb begin
      ctl.rd      = rw;
      ctl.io_sel  = ~io_sel_n;
      ctl.io_strb = ~io_strb_n;
      ctl.dev_sel = ~dev_sel_n;
   end

   // Device-select cycles never reach the memory
   assign mem_act = (ctl.io_sel | ctl.io_strb) & ~ctl.dev_sel;
   assign cs_n    = ~mem_act;

   generate
      if (GATE_RW_WITH_CS) begin : g_gated
         assign oe_n = ~(mem_act & ctl.rd);
         assign we_n = ~(mem_act & ~ctl.rd);
      end else begin : g_plain
         assign oe_n = ~ctl.rd;
         assign we_n = ctl.rd;
      end
   endgenerate

endmodule

// File: rtl/rom_bank_reg.sv
module rom_bank_reg #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BANK_W    = 2,
   parameter logic [ADDR_W-1:0] KEY_BASE = 16'hCFFC,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strb_act,
   input  logic              dev_act,
   output logic [BANK_W-1:0] bank_q
);

   localparam logic [BANK_W-1:0] RESERVED = {BANK_W{1'b1}};

   logic              key_hit;
   logic [BANK_W-1:0] bank_d;

   generate
      if (KEY_BASE[BANK_W-1:0] != '0) begin : g_bad_base
         $error("rom_bank_reg: KEY_BASE must be aligned to the bank count");
      end
   endgenerate

   // Key range: aligned group whose low bits name the bank; all-ones is inert
   assign key_hit = strb_act & ~dev_act
                  & (addr[ADDR_W-1:BANK_W] == KEY_BASE[ADDR_W-1:BANK_W])
                  & (addr[BANK_W-1:0] != RESERVED);

   assign bank_d = key_hit ? addr[BANK_W-1:0] : bank_q;

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q <= '0;
            else        bank_q <= bank_d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) bank_q <= '0;
            else        bank_q <= bank_d;
         end
      end
   endgenerate

endmodule

// File: rtl/rom_hi_mux.sv
module rom_hi_mux #(
   parameter int unsigned BANK_W = 2,
   parameter logic [BANK_W-1:0] SLOT_BANK = '1
) (
   input  logic              slot_act,
   input  logic [BANK_W-1:0] bank_q,
   output logic [BANK_W-1:0] mem_hi
);

   assign mem_hi = slot_act ? SLOT_BANK : bank_q;

endmodule

// File: rtl/exp_rom_bank_decoder.sv
module exp_rom_bank_decoder
   import rom_dec_pkg::*;
#(
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned LOW_W     = DEF_LOW_W,
   parameter int unsigned BANK_W    = DEF_BANK_W,
   parameter logic [ADDR_W-1:0] KEY_BASE = 16'hCFFC,
   parameter bit          ASYNC_RST = 1'b1,
   parameter bit          GATE_RW   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw,
   input  logic              io_sel_n,
   input  logic              io_strb_n,
   input  logic              dev_sel_n,
   output logic [BANK_W-1:0] mem_hi,
   output logic [LOW_W-1:0]  mem_lo,
   output logic              cs_n,
   output logic              oe_n,
   output logic              we_n
);

   localparam logic [BANK_W-1:0] SLOT_BANK = {BANK_W{1'b1}};

   generate
      if (LOW_W + BANK_W > ADDR_W) begin : g_bad_width
         $error("exp_rom_bank_decoder: memory address wider than host bus");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("exp_rom_bank_decoder: BANK_W must be at least 1");
      end
   endgenerate

   bus_ctl_t          ctl;
   logic [BANK_W-1:0] bank_q;

   rom_ctl_decode #(
      .GATE_RW_WITH_CS (GATE_RW)
   ) i_ctl (
      .rw        (rw),
      .io_sel_n  (io_sel_n),
      .io_strb_n (io_strb_n),
      .dev_sel_n (dev_sel_n),
      .ctl       (ctl),
      .cs_n      (cs_n),
      .oe_n      (oe_n),
      .we_n      (we_n)
   );

   rom_bank_reg #(
      .ADDR_W    (ADDR_W),
      .BANK_W    (BANK_W),
      .KEY_BASE  (KEY_BASE),
      .ASYNC_RST (ASYNC_RST)
   ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .strb_act (ctl.io_strb & ~ctl.io_sel),
      .dev_act  (ctl.dev_sel),
      .bank_q   (bank_q)
   );

   rom_hi_mux #(
      .BANK_W    (BANK_W),
      .SLOT_BANK (SLOT_BANK)
   ) i_mux (
      .slot_act (ctl.io_sel),
      .bank_q   (bank_q),
      .mem_hi   (mem_hi)
   );

   assign mem_lo = addr[LOW_W-1:0];

   // ctl.rd is consumed inside i_ctl only
   logic unused_rd;
   assign unused_rd = ctl.rd;

endmodule

// File: rtl/rom_dec_chk.sv
module rom_dec_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] addr,
   input logic        rw,
   input logic        io_sel_n,
   input logic        io_strb_n,
   input logic        dev_sel_n,
   input logic [1:0]  mem_hi,
   input logic        cs_n,
   input logic        oe_n,
   input logic        we_n
);

   logic key_cyc;
   assign key_cyc = !io_strb_n && io_sel_n && dev_sel_n
                  && (addr[15:2] == 14'h33FF) && (addr[1:0] != 2'b11);

   // R2
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_cyc ##1 io_sel_n) |-> (mem_hi == $past(addr[1:0])));

   // R3
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_cyc && io_sel_n ##1 io_sel_n) |-> $stable(mem_hi));

   // R4
   slot_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_sel_n |-> (mem_hi == 2'b11));

   // R8
   dev_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_sel_n |-> cs_n);

   // R7
   rw_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n != we_n) && (we_n == rw));

endmodule

bind exp_rom_bank_decoder rom_dec_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .rw        (rw),
   .io_sel_n  (io_sel_n),
   .io_strb_n (io_strb_n),
   .dev_sel_n (dev_sel_n),
   .mem_hi    (mem_hi),
   .cs_n      (cs_n),
   .oe_n      (oe_n),
   .we_n      (we_n)
);

// File: tb/test_exp_rom_bank_decoder.sv
`timescale 1ns/1ps
module test_exp_rom_bank_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        rw = 1'b1;
   logic        io_sel_n = 1'b1;
   logic        io_strb_n = 1'b1;
   logic        dev_sel_n = 1'b1;
   logic [1:0]  mem_hi;
   logic [10:0] mem_lo;
   logic        cs_n, oe_n, we_n;

   int vectors = 0;
   int fails = 0;
   int ref_bank = 0;

   always #2.5 clk = ~clk;

   exp_rom_bank_decoder i_exp_rom_bank_decoder (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw),
      .io_sel_n(io_sel_n), .io_strb_n(io_strb_n), .dev_sel_n(dev_sel_n),
      .mem_hi(mem_hi), .mem_lo(mem_lo), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n)
   );

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: got %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // Reference model: one bus cycle, outputs compared before the closing edge
   task automatic cycle(string tag, int a, bit r, bit sel, bit strb, bit dev);
      int exp_hi;
      bit exp_cs;
      @(negedge clk);
      addr = a[15:0]; rw = r; io_sel_n = sel; io_strb_n = strb; dev_sel_n = dev;
      #1;
      exp_hi = (sel == 1'b0) ? 3 : ref_bank;
      exp_cs = !(((sel == 1'b0) || (strb == 1'b0)) && (dev == 1'b1));
      check((sel == 1'b0) ? "R4" : tag, int'(mem_hi), exp_hi);
      check("R5", int'(mem_lo), a % 2048);
      check((dev == 1'b0) ? "R8" : "R6", int'(cs_n), int'(exp_cs));
      check("R7", int'(we_n), int'(r));
      check("R7", int'(oe_n), int'(!r));
      @(posedge clk);
      if (rst_n && strb == 1'b0 && sel == 1'b1 && dev == 1'b1
          && (a / 4) == ('hCFFC / 4) && (a % 4) != 3)
         ref_bank = a % 4;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ref_bank = 0;
      repeat (3) cycle("R1", 'hC900, 1'b1, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1: bank 0 seen right after reset
      cycle("R1", 'hC800, 1'b1, 1'b1, 0, 1);
      cycle("R9", 'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
      // R2: each key address, then a window read
      cycle("R2", 'hCFFD, 1'b1, 1'b1, 0, 1);
      cycle("R2", 'hC800, 1'b1, 1'b1, 0, 1);
      cycle("R2", 'hCFFE, 1'b0, 1'b1, 0, 1);
      cycle("R2", 'hCA10, 1'b0, 1'b1, 0, 1);
      cycle("R2", 'hCFFC, 1'b1, 1'b1, 0, 1);
      cycle("R2", 'hCC00, 1'b1, 1'b1, 0, 1);
      cycle("R2", 'hCFFE, 1'b1, 1'b1, 0, 1);
      // R3: CFFF and the lower CFFx addresses are inert
      cycle("R3", 'hCFFF, 1'b1, 1'b1, 0, 1);
      cycle("R3", 'hC800, 1'b1, 1'b1, 0, 1);
      for (int k = 'hCFF0; k <= 'hCFFB; k++) cycle("R3", k, 1'b1, 1'b1, 0, 1);
      cycle("R3", 'hC800, 1'b1, 1'b1, 0, 1);
      // R4: slot cycles force bank 3, even at a key address, bank kept
      cycle("R4", 'hC300, 1'b1, 0, 1'b1, 1'b1);
      cycle("R4", 'hCFFD, 1'b1, 0, 0, 1'b1);
      cycle("R9", 'hC800, 1'b1, 1'b1, 0, 1);
      cycle("R4", 'hC7FF, 1'b0, 0, 1'b1, 1'b1);
      // R8: device-select cycles, alone and with strobe at a key address
      cycle("R8", 'hC0E0, 1'b1, 1'b1, 1'b1, 0);
      cycle("R8", 'hCFFC, 1'b1, 1'b1, 0, 0);
      cycle("R8", 'hC800, 1'b1, 1'b1, 0, 1);
      // R1: reset in mid-run returns to bank 0
      cycle("R2", 'hCFFD, 1'b1, 1'b1, 0, 1);
      do_reset();
      cycle("R1", 'hC800, 1'b1, 1'b1, 0, 1);
      // Mixed traffic biased toward the key area
      for (int n = 0; n < 600; n++) begin
         int a;
         bit s, t, d;
         a = ($urandom % 2 == 0) ? ('hCFF0 + ($urandom % 16)) : int'($urandom % 65536);
         s = ($urandom % 5 != 0);
         t = ($urandom % 2 != 0);
         d = ($urandom % 7 != 0);
         cycle("R9", a, 1'(($urandom % 2)), s, t, d);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule